// File: doc/BRIEF.md
# Hybrid Lane-Sequenced Vector ALU

This block runs one vector instruction over a logical vector of up to 16 integer elements of 16 bits each. Inside, four identical ALU lanes handle one group of four elements per clock. A small sequencer walks the groups one after another, so a full vector takes four group steps. The requester sees none of this stepping. It hands over an opcode, a length and two operand vectors in a single valid/ready transfer, and later receives one done pulse together with the finished result vector.

The parallelism depends on the operation. Addition, subtraction and the three bitwise operations use all four lanes. Integer square root is rare and costly, so it is not copied into every lane. It goes through one shared iterative unit that handles a single element at a time and produces one result bit per clock. Both paths give the same result for the same data; only the number of cycles differs.

When the length is not a multiple of four, the unused lanes of the last group stay idle. Result slots at or beyond the length keep whatever the previous instruction left there.

Top module: `vec_hybrid_alu`

## Requirements
- R1: `in_ready` is high whenever no instruction is in progress. An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. For a length of one or more, `in_ready` is low from that edge until the edge that raises `out_done`.
- R2: Opcode encodings on `in_op` apply per element, modulo 2^16: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b. Element i sits at bits [16*i+15:16*i] of `in_a`, `in_b` and `out_result`.
- R3: Opcodes 0 to 4 and 6 to 7 use the four-lane path. For an effective length L, `out_done` rises on the ceil(L/4)-th rising edge after the accepting edge.
- R4: Opcode 5 writes floor(sqrt(a)) of each element, zero-extended to 16 bits, and ignores `in_b`. It processes one element at a time, each taking 9 cycles, so `out_done` rises on the 9*L-th edge after the accepting edge.
- R5: Result slots with an index at or beyond the effective length keep their previous value.
- R6: A length of 0 raises `out_done` on the accepting edge itself and leaves `out_result` unchanged.
- R7: A length above 16 is treated as 16.
- R8: `out_done` is a one-cycle pulse and is only high while `in_ready` is high. `out_result` does not change while the block is idle and accepts nothing.
- R9: Opcodes 6 and 7 write zero to every active slot.
- R10: A synchronous active-high `rst` clears all result slots to zero, drives `out_done` low and returns the block to idle with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction request |
| in_ready | output | 1 | Block idle and able to take a request |
| in_op | input | 3 | Operation code |
| in_len | input | 5 | Number of elements, 0 to 16 (larger values are clamped) |
| in_a | input | 256 | First operand vector, 16 elements of 16 bits |
| in_b | input | 256 | Second operand vector, 16 elements of 16 bits |
| out_done | output | 1 | One-cycle completion pulse |
| out_result | output | 256 | Registered result vector |

## Verification
Results are due a fixed number of edges after the accepting edge, and that number depends only on the opcode and the effective length. The count is 0 for an empty vector, ceil(L/4) for the lane path and 9*L for square root. The bench samples on falling edges. It counts the cycles from acceptance until it sees `out_done`, and it compares that count with the figure above plus the one sampling cycle. It then compares every result slot with a value computed in the bench: active slots against the operation, inactive slots against the slot contents from the previous instruction. The falling edge that follows must show `out_done` low again.

// File: rtl/vha_pkg.sv
package vha_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_ISQRT = 3'd5
  } vha_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LANE = 2'd1,
    ST_ROOT = 2'd2
  } vha_state_e;

endpackage

// File: rtl/vha_lane.sv
module vha_lane #(
  parameter int DW = 16
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  import vha_pkg::*;

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/vha_isqrt.sv
module vha_isqrt #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] x,
  output logic          valid,
  output logic [DW-1:0] root
);
  localparam int STEPS = DW / 2;
  localparam int CW    = $clog2(STEPS + 1);

  logic [DW-1:0] rem_q, acc_q, bit_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic [DW:0]   trial;

  assign trial = {1'b0, acc_q} + {1'b0, bit_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      acc_q   <= '0;
      bit_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start) begin
      rem_q   <= x;
      acc_q   <= '0;
      bit_q   <= DW'(1) << (DW - 2);
      cnt_q   <= CW'(STEPS);
      valid_q <= 1'b0;
    end else if (cnt_q != '0) begin
      if ({1'b0, rem_q} >= trial) begin
        rem_q <= rem_q - trial[DW-1:0];
        acc_q <= (acc_q >> 1) + bit_q;
      end else begin
        acc_q <= acc_q >> 1;
      end
      bit_q   <= bit_q >> 2;
      cnt_q   <= cnt_q - CW'(1);
      valid_q <= (cnt_q == CW'(1));
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign valid = valid_q;
  assign root  = acc_q;

endmodule

// File: rtl/vec_hybrid_alu.sv
module vec_hybrid_alu #(
  parameter  int ELEMS = 16,
  parameter  int LANES = 4,
  parameter  int DW    = 16,
  localparam int LW    = $clog2(ELEMS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_op,
  input  logic [LW-1:0]       in_len,
  input  logic [ELEMS*DW-1:0] in_a,
  input  logic [ELEMS*DW-1:0] in_b,
  output logic                out_done,
  output logic [ELEMS*DW-1:0] out_result
);
  import vha_pkg::*;

  localparam int GROUPS = (ELEMS + LANES - 1) / LANES;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int IW     = (ELEMS > 1) ? $clog2(ELEMS) : 1;

  vha_state_e    state_q;
  logic [2:0]    op_q;
  logic [LW-1:0] len_q;
  logic [GW-1:0] grp_q;
  logic [IW-1:0] idx_q;
  logic          done_q;
  logic [DW-1:0] a_q   [ELEMS];
  logic [DW-1:0] b_q   [ELEMS];
  logic [DW-1:0] res_q [ELEMS];

  logic          accept;
  logic          is_root;
  logic [LW-1:0] len_c;
  logic          last_grp;
  logic          last_el;

  logic [DW-1:0] lane_a    [LANES];
  logic [DW-1:0] lane_b    [LANES];
  logic [DW-1:0] lane_y    [LANES];
  logic          lane_en   [LANES];
  logic [IW-1:0] lane_slot [LANES];

  logic          sq_start;
  logic [DW-1:0] sq_x;
  logic          sq_valid;
  logic [DW-1:0] sq_root;
  logic [IW-1:0] idx_nxt;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign is_root  = (in_op == OP_ISQRT);
  assign len_c    = (int'(in_len) > ELEMS) ? LW'(ELEMS) : in_len;
  assign last_grp = ((int'(grp_q) + 1) * LANES) >= int'(len_q);
  assign last_el  = (int'(idx_q) + 1) >= int'(len_q);
  assign idx_nxt  = idx_q + IW'(1);

  // Group-to-lane operand steering
  always_comb begin
    int e;
    for (int l = 0; l < LANES; l++) begin
      e            = int'(grp_q) * LANES + l;
      lane_en[l]   = (e < int'(len_q));
      lane_slot[l] = IW'(e % ELEMS);
      lane_a[l]    = a_q[lane_slot[l]];
      lane_b[l]    = b_q[lane_slot[l]];
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      vha_lane #(.DW(DW)) u_lane (
        .op (op_q),
        .a  (lane_a[g]),
        .b  (lane_b[g]),
        .y  (lane_y[g])
      );
    end
  endgenerate

  // Single shared root unit, fed one element at a time
  assign sq_start = (accept && is_root && (len_c != '0)) ||
                    ((state_q == ST_ROOT) && sq_valid && !last_el);
  assign sq_x     = (state_q == ST_IDLE) ? in_a[DW-1:0] : a_q[idx_nxt];

  vha_isqrt #(.DW(DW)) u_root (
    .clk   (clk),
    .rst   (rst),
    .start (sq_start),
    .x     (sq_x),
    .valid (sq_valid),
    .root  (sq_root)
  );

  // Operand capture (no reset needed)
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < ELEMS; i++) begin
        a_q[i] <= in_a[i*DW +: DW];
        b_q[i] <= in_b[i*DW +: DW];
      end
    end
  end

  // Sequencer and result register
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      len_q   <= '0;
      grp_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      for (int i = 0; i < ELEMS; i++) res_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q  <= in_op;
            len_q <= len_c;
            grp_q <= '0;
            idx_q <= '0;
            if (len_c == '0)  done_q  <= 1'b1;
            else if (is_root) state_q <= ST_ROOT;
            else              state_q <= ST_LANE;
          end
        end
        ST_LANE: begin
          for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) res_q[lane_slot[l]] <= lane_y[l];
          end
          if (last_grp) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            grp_q <= grp_q + GW'(1);
          end
        end
        ST_ROOT: begin
          if (sq_valid) begin
            res_q[idx_q] <= sq_root;
            if (last_el) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_nxt;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_done = done_q;

  always_comb begin
    for (int i = 0; i < ELEMS; i++) out_result[i*DW +: DW] = res_q[i];
  end

endmodule

// File: rtl/vha_chk.sv
module vha_chk #(
  parameter int ELEMS = 16,
  parameter int DW    = 16,
  parameter int LW    = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LW-1:0]       in_len,
  input logic                out_done,
  input logic [ELEMS*DW-1:0] out_result
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_len != '0) |=> !in_ready); // R1

  AST_EMPTY_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_len == '0) |=> (out_done && $stable(out_result))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (out_done && !(in_valid && in_ready)) |=> !out_done); // R8

  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    out_done |-> in_ready); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(out_result)); // R8

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (out_result == '0 && !out_done && in_ready)); // R10

endmodule

bind vec_hybrid_alu vha_chk #(.ELEMS(ELEMS), .DW(DW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_len     (in_len),
  .out_done   (out_done),
  .out_result (out_result)
);

// File: tb/vec_hybrid_alu_tb.sv
module vec_hybrid_alu_tb;
  localparam int ELEMS = 16;
  localparam int DW    = 16;
  localparam int LW    = 5;
  localparam int VW    = ELEMS * DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [LW-1:0] in_len = '0;
  logic [VW-1:0] in_a = '0;
  logic [VW-1:0] in_b = '0;
  logic          out_done;
  logic [VW-1:0] out_result;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [DW-1:0] va   [ELEMS];
  logic [DW-1:0] vb   [ELEMS];
  logic [DW-1:0] expv [ELEMS];

  always #2.5 clk = ~clk;

  vec_hybrid_alu u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_op      (in_op),
    .in_len     (in_len),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_done   (out_done),
    .out_result (out_result)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] root_model(input logic [DW-1:0] x);
    logic [DW-1:0] r = '0;
    for (int k = 0; k < 256; k++) if (k * k <= int'(x)) r = DW'(k);
    return r;
  endfunction

  function automatic logic [DW-1:0] op_model(input logic [2:0] op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (op)
      3'd0:    return a + b;
      3'd1:    return a - b;
      3'd2:    return a & b;
      3'd3:    return a | b;
      3'd4:    return a ^ b;
      3'd5:    return root_model(a);
      default: return '0;
    endcase
  endfunction

  // Issue one instruction and check timing, result and the done pulse
  task automatic run(input logic [2:0] op, input int len);
    int lc, edges, cyc;
    logic [VW-1:0] prev, exp_flat, act_mask, exp_mask;
    string rq;
    lc    = (len > ELEMS) ? ELEMS : len;
    edges = (lc == 0) ? 0 : (op == 3'd5) ? 9 * lc : (lc + 3) / 4;
    rq    = (lc == 0) ? "R6" : (op == 3'd5) ? "R4" : "R3";
    prev  = out_result;
    for (int i = 0; i < ELEMS; i++) if (i < lc) expv[i] = op_model(op, va[i], vb[i]);
    for (int i = 0; i < ELEMS; i++) exp_flat[i*DW +: DW] = expv[i];
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", "ready before issue", VW'(in_ready), VW'(1));
    in_valid = 1'b1;
    in_op    = op;
    in_len   = LW'(len);
    for (int i = 0; i < ELEMS; i++) begin
      in_a[i*DW +: DW] = va[i];
      in_b[i*DW +: DW] = vb[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1;
    if (lc != 0) chk(in_ready === 1'b0, "R1", "ready low while busy", VW'(in_ready), VW'(0));
    while (out_done !== 1'b1 && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == edges + 1, rq, "done latency", VW'(cyc), VW'(edges + 1));
    act_mask = '0;
    exp_mask = '0;
    for (int i = 0; i < ELEMS; i++) begin
      if (i < lc) begin
        act_mask[i*DW +: DW] = out_result[i*DW +: DW];
        exp_mask[i*DW +: DW] = exp_flat[i*DW +: DW];
      end
    end
    chk(act_mask === exp_mask,
        (op > 3'd5) ? "R9" : (op == 3'd5) ? "R4" : (len > ELEMS) ? "R7" : "R2",
        "active slots", act_mask, exp_mask);
    if (lc < ELEMS) begin
      act_mask = '0;
      exp_mask = '0;
      for (int i = 0; i < ELEMS; i++) begin
        if (i >= lc) begin
          act_mask[i*DW +: DW] = out_result[i*DW +: DW];
          exp_mask[i*DW +: DW] = prev[i*DW +: DW];
        end
      end
      chk(act_mask === exp_mask, (lc == 0) ? "R6" : "R5", "idle slots kept", act_mask, exp_mask);
    end
    chk(in_ready === 1'b1, "R8", "ready with done", VW'(in_ready), VW'(1));
    @(negedge clk);
    chk(out_done === 1'b0, "R8", "done is one pulse", VW'(out_done), VW'(0));
  endtask

  initial begin
    void'($urandom(32'd24681357));
    for (int i = 0; i < ELEMS; i++) begin
      va[i] = '0; vb[i] = '0; expv[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(out_result === '0, "R10", "result cleared", out_result, '0);
    chk(out_done === 1'b0, "R10", "done low", VW'(out_done), VW'(0));
    chk(in_ready === 1'b1, "R10", "ready high", VW'(in_ready), VW'(1));
    rst = 1'b0;

    // Directed corners
    for (int i = 0; i < ELEMS; i++) begin va[i] = 16'hFFF0 + DW'(i); vb[i] = 16'h0021; end
    run(3'd0, 16);                                   // R2 wrap-around add
    for (int i = 0; i < ELEMS; i++) begin va[i] = DW'(i); vb[i] = 16'h0005; end
    run(3'd1, 5);                                    // R5 partial group, borrow
    run(3'd2, 0);                                    // R6 empty vector
    va[0] = 16'd0; va[1] = 16'd1; va[2] = 16'hFFFF; va[3] = 16'd15;
    va[4] = 16'd16; va[5] = 16'd65025; va[6] = 16'd65024; va[7] = 16'd99;
    for (int i = 8; i < ELEMS; i++) va[i] = DW'(i * 1000);
    run(3'd5, 16);                                   // R4 full root vector
    run(3'd5, 3);                                    // R4 short root vector
    for (int i = 0; i < ELEMS; i++) begin va[i] = 16'hA5A5; vb[i] = 16'h0FF0; end
    run(3'd4, 20);                                   // R7 clamped length
    run(3'd6, 7);                                    // R9 unused opcode
    run(3'd3, 4);                                    // R3 exactly one group

    // Idle hold check
    repeat (4) @(negedge clk);
    begin
      logic [VW-1:0] snap;
      snap = out_result;
      repeat (3) @(negedge clk);
      chk(out_result === snap, "R8", "idle result stable", out_result, snap);
    end

    // Constrained random mix
    for (int t = 0; t < 250; t++) begin
      for (int i = 0; i < ELEMS; i++) begin
        va[i] = DW'($urandom);
        vb[i] = DW'($urandom);
      end
      run(3'($urandom % 8), int'($urandom % 21));
    end
    summary();
  end

endmodule